// File: doc/BRIEF.md
# Serial Register Port with FIFO Gateway

This block is an SPI slave that lets a host controller reach the control plane of a packet radio. The host sees a 128-location byte address space. A handful of locations hold the interrupt flags and enables, a mode byte, FIFO clear controls and a status byte. Every other location reads as zero. Location 0x7F is a gateway into two byte FIFOs. Host writes to it fill the transmit FIFO, which the radio datapath drains. Host reads from it empty the receive FIFO, which the radio datapath fills.

Each access opens when select falls and closes when it rises. The host clocks whole bytes, most significant bit first. The first byte is a command: a direction bit and a start address. The bytes that follow are data. The address steps up by one after each data byte. It stays frozen once it reaches the gateway, so a single burst can stream a whole packet. Radio events set interrupt flags. A flag that is enabled pulls the active-low interrupt output down. When the host reads a flag register, the flags it was shown are cleared.

The SPI pins are oversampled by the system clock through a configurable synchronizer. SCK must therefore stay at each level for several system clock cycles.

Top module: `spi_rf_regif`

## Requirements
- R1: Transfers use SPI mode 0, 8 bits, MSB first. The first byte after select falls is the command: bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 give the start address. miso_o is 0 while the command byte shifts and while select is high.
- R2: After each data byte of a burst, the address moves to the next higher location. A read burst returns the contents of consecutive locations.
- R3: Address 0x7F does not advance. Every write byte sent to it is pushed into the TX FIFO (tx_data_o shows the oldest byte). Every read byte taken from it pops the RX FIFO. A burst that starts at 0x7E writes 0x7E once and then stays at 0x7F.
- R4: The bytes 0x87 then 0x01 within one select window store 0x01 in the mode register at 0x07, which drives mode_o. Register 0x05 is enable[7:0] and register 0x06 is enable[15:8]; both are read/write.
- R5: Each FIFO holds FIFO_DEPTH bytes (default 64). The following events set flag bit 7 (register 0x03) and change no data: a write when full (host or radio side), and a read when empty (host or radio side). A host read from an empty RX FIFO returns 0x00.
- R6: Reading 0x03 (flags[7:0]) or 0x04 (flags[15:8]) clears exactly the bits that were returned. The clear happens only once the host clocks the first bit of that data byte. An event that arrives in the meantime is kept.
- R7: A pulse on evt_i[i] sets flags[i]. irq_n_o goes low within two clock cycles whenever (flags & enable) is nonzero, and returns high within two cycles after that becomes zero.
- R8: Register 0x08 is read/write. When bit 0 changes from 1 to 0 under a host write, the TX FIFO is emptied. Bit 1 does the same for the RX FIFO.
- R9: Register 0x02 is read-only status: bit 5 = RX FIFO empty, bits 1:0 = pwr_state_i (00 idle, 01 receive, 10 transmit), all other bits 0.
- R10: Reads of unimplemented addresses return 0x00 and writes to them are ignored. Writes to 0x02, 0x03 and 0x04 have no effect.
- R11: If select rises in the middle of a byte, that byte is discarded. A partial write byte changes no register.
- R12: After reset the flags, enables, mode and FIFO control are 0, both FIFOs are empty, irq_n_o is high and miso_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SPI pins are oversampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock from the host |
| cs_ni | input | 1 | Active-low select framing one access |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| irq_n_o | output | 1 | Active-low interrupt request |
| mode_o | output | 8 | Contents of the mode register |
| pwr_state_i | input | 2 | Power state reported in status |
| evt_i | input | 16 | Per-flag event pulses from the radio |
| tx_pop_i | input | 1 | Radio takes one byte from the TX FIFO |
| tx_data_o | output | 8 | Oldest TX FIFO byte |
| tx_empty_o | output | 1 | TX FIFO is empty |
| rx_push_i | input | 1 | Radio stores one byte into the RX FIFO |
| rx_data_i | input | 8 | Byte stored by rx_push_i |

## Verification
The bench builds the block with FIFO_DEPTH = 8 and SYNC_STAGES = 2. The shallow FIFOs let short gateway bursts reach full and overflow, and let one extra pop reach underflow, so both FIFO error paths and the clear controls are exercised in a few transfers. The synchronizer depth fixes the lag between pin activity and its effect. The bench holds each SCK level for eight system clocks so that command decode, prefetch and load all finish between edges.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam logic [6:0] A_STATUS  = 7'h02;
  localparam logic [6:0] A_FLAG_LO = 7'h03;
  localparam logic [6:0] A_FLAG_HI = 7'h04;
  localparam logic [6:0] A_EN_LO   = 7'h05;
  localparam logic [6:0] A_EN_HI   = 7'h06;
  localparam logic [6:0] A_MODE    = 7'h07;
  localparam logic [6:0] A_FCTL    = 7'h08;
  localparam logic [6:0] A_GATE    = 7'h7F;

  localparam int unsigned FCTL_TX_CLR   = 0;
  localparam int unsigned FCTL_RX_CLR   = 1;
  localparam int unsigned FLAG_FIFO_ERR = 7;
endpackage

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  output logic       sel_o,
  output logic       byte_done_o,
  output logic       first_rise_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic [SYNC_STAGES-1:0] sck_q, cs_q, mosi_q;
  logic sck_s, cs_s, mosi_s, sck_d, rise, fall;
  logic [2:0] bit_cnt;
  logic [6:0] in_sr;
  logic [7:0] out_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= (sck_q << 1)  | SYNC_STAGES'(sck_i);
      cs_q   <= (cs_q << 1)   | SYNC_STAGES'(cs_ni);
      mosi_q <= (mosi_q << 1) | SYNC_STAGES'(mosi_i);
      sck_d  <= sck_s;
    end
  end

  assign sck_s  = sck_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];
  assign sel_o  = ~cs_s;
  assign rise   = sel_o & sck_s & ~sck_d;
  assign fall   = sel_o & ~sck_s & sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
    end else if (!sel_o) begin
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
    end else begin
      if (rise) begin
        in_sr   <= {in_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      // no shift on the falling edge between bytes: next byte's MSB is already out
      if (fall && bit_cnt != 3'd0) out_sr <= {out_sr[6:0], 1'b0};
      if (load_i) out_sr <= load_data_i;
    end
  end

  assign byte_done_o  = rise & (bit_cnt == 3'd7);
  assign first_rise_o = rise & (bit_cnt == 3'd0);
  assign rx_byte_o    = {in_sr, mosi_s};
  assign miso_o       = sel_o & out_sr[7];
endmodule

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [AW:0]      level_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign level_o = wr_ptr - rd_ptr;
  assign full_o  = (level_o == (AW+1)'(DEPTH));
  assign empty_o = (level_o == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        byte_done_i,
  input  logic        first_rise_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        tx_full_i,
  input  logic        rx_empty_i,
  input  logic [7:0]  rx_dout_i,
  input  logic [1:0]  pwr_i,
  input  logic [15:0] evt_i,
  input  logic        ext_err_i,
  output logic        load_o,
  output logic [7:0]  load_data_o,
  output logic        tx_push_o,
  output logic [7:0]  tx_wdata_o,
  output logic        rx_pop_o,
  output logic        tx_flush_o,
  output logic        rx_flush_o,
  output logic [15:0] flags_o,
  output logic        irq_n_o,
  output logic [7:0]  mode_o,
  output logic [6:0]  addr_o,
  output logic        in_cmd_o
);
  logic        in_cmd, is_wr, pend, pend_empty;
  logic [6:0]  addr, nxt, fetch_addr, pend_addr;
  logic [7:0]  rd_val, pend_val, mode, fctl;
  logic [15:0] flags, en, clr, flags_nxt;
  logic        fetch_en, wr_en, commit, err;

  assign nxt        = (addr == A_GATE) ? addr : addr + 7'd1;
  assign fetch_en   = byte_done_i & (in_cmd ? ~rx_byte_i[7] : ~is_wr);
  assign fetch_addr = in_cmd ? rx_byte_i[6:0] : nxt;
  assign wr_en      = byte_done_i & ~in_cmd & is_wr;
  assign commit     = first_rise_i & pend;

  always_comb begin
    unique case (fetch_addr)
      A_STATUS:  rd_val = {2'b00, rx_empty_i, 3'b000, pwr_i};
      A_FLAG_LO: rd_val = flags[7:0];
      A_FLAG_HI: rd_val = flags[15:8];
      A_EN_LO:   rd_val = en[7:0];
      A_EN_HI:   rd_val = en[15:8];
      A_MODE:    rd_val = mode;
      A_FCTL:    rd_val = fctl;
      A_GATE:    rd_val = rx_empty_i ? 8'h00 : rx_dout_i;
      default:   rd_val = 8'h00;
    endcase
  end

  assign tx_push_o  = wr_en & (addr == A_GATE) & ~tx_full_i;
  assign tx_wdata_o = rx_byte_i;
  assign rx_pop_o   = commit & (pend_addr == A_GATE) & ~pend_empty;
  assign err = (wr_en & (addr == A_GATE) & tx_full_i)
             | (commit & (pend_addr == A_GATE) & pend_empty)
             | ext_err_i;

  // read-clear acts only on the bits the host was shown
  always_comb begin
    clr = '0;
    if (commit && pend_addr == A_FLAG_LO) clr[7:0]  = pend_val;
    if (commit && pend_addr == A_FLAG_HI) clr[15:8] = pend_val;
    flags_nxt = (flags & ~clr) | evt_i;
    flags_nxt[FLAG_FIFO_ERR] = flags_nxt[FLAG_FIFO_ERR] | err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cmd <= 1'b1; is_wr <= 1'b0; addr <= '0;
      pend <= 1'b0; pend_addr <= '0; pend_val <= '0; pend_empty <= 1'b0;
      flags <= '0; en <= '0; mode <= '0; fctl <= '0;
      load_o <= 1'b0; load_data_o <= '0; irq_n_o <= 1'b1;
      tx_flush_o <= 1'b0; rx_flush_o <= 1'b0;
    end else begin
      flags      <= flags_nxt;
      irq_n_o    <= ~|(flags & en);
      load_o     <= fetch_en;
      tx_flush_o <= 1'b0;
      rx_flush_o <= 1'b0;
      if (commit) pend <= 1'b0;
      if (fetch_en) begin
        load_data_o <= rd_val;
        pend        <= 1'b1;
        pend_addr   <= fetch_addr;
        pend_val    <= rd_val;
        pend_empty  <= rx_empty_i;
      end
      if (!sel_i) begin
        in_cmd <= 1'b1;
        pend   <= 1'b0;
      end else if (byte_done_i) begin
        if (in_cmd) begin
          in_cmd <= 1'b0;
          is_wr  <= rx_byte_i[7];
          addr   <= rx_byte_i[6:0];
        end else begin
          addr <= nxt;
        end
      end
      if (wr_en) begin
        unique case (addr)
          A_EN_LO: en[7:0]  <= rx_byte_i;
          A_EN_HI: en[15:8] <= rx_byte_i;
          A_MODE:  mode     <= rx_byte_i;
          A_FCTL: begin
            fctl       <= rx_byte_i;
            tx_flush_o <= fctl[FCTL_TX_CLR] & ~rx_byte_i[FCTL_TX_CLR];
            rx_flush_o <= fctl[FCTL_RX_CLR] & ~rx_byte_i[FCTL_RX_CLR];
          end
          default: ;
        endcase
      end
    end
  end

  assign flags_o  = flags;
  assign mode_o   = mode;
  assign addr_o   = addr;
  assign in_cmd_o = in_cmd;
endmodule

// File: rtl/spi_rf_regif.sv
module spi_rf_regif #(
  parameter int unsigned FIFO_DEPTH  = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        irq_n_o,
  output logic [7:0]  mode_o,
  input  logic [1:0]  pwr_state_i,
  input  logic [15:0] evt_i,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_empty_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i
);
  logic sel, byte_done, first_rise, load, in_cmd;
  logic [7:0] rx_byte, load_data, tx_wdata, rx_dout;
  logic tx_push, rx_pop, tx_flush, rx_flush, tx_full, rx_full, rx_empty, ext_err;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [15:0] flags;
  logic [6:0] cur_addr;

  spi_rf_shifter #(.SYNC_STAGES(SYNC_STAGES)) i_shifter (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .load_i(load), .load_data_i(load_data),
    .sel_o(sel), .byte_done_o(byte_done), .first_rise_o(first_rise),
    .rx_byte_o(rx_byte), .miso_o
  );

  assign ext_err = (tx_pop_i & tx_empty_o) | (rx_push_i & rx_full);

  spi_rf_regs i_regs (
    .clk_i, .rst_ni, .sel_i(sel), .byte_done_i(byte_done), .first_rise_i(first_rise),
    .rx_byte_i(rx_byte), .tx_full_i(tx_full), .rx_empty_i(rx_empty), .rx_dout_i(rx_dout),
    .pwr_i(pwr_state_i), .evt_i, .ext_err_i(ext_err),
    .load_o(load), .load_data_o(load_data), .tx_push_o(tx_push), .tx_wdata_o(tx_wdata),
    .rx_pop_o(rx_pop), .tx_flush_o(tx_flush), .rx_flush_o(rx_flush), .flags_o(flags),
    .irq_n_o, .mode_o, .addr_o(cur_addr), .in_cmd_o(in_cmd)
  );

  spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .din_i(tx_wdata),
    .pop_i(tx_pop_i), .dout_o(tx_data_o), .full_o(tx_full), .empty_o(tx_empty_o),
    .level_o(tx_cnt)
  );

  spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push_i), .din_i(rx_data_i),
    .pop_i(rx_pop), .dout_o(rx_dout), .full_o(rx_full), .empty_o(rx_empty),
    .level_o(rx_cnt)
  );
endmodule

// File: rtl/spi_rf_chk.sv
module spi_rf_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          miso_o,
  input logic          irq_n_o,
  input logic [LW-1:0] tx_cnt,
  input logic [LW-1:0] rx_cnt,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic [15:0]   flags,
  input logic          byte_done,
  input logic          in_cmd,
  input logic [6:0]    cur_addr
);
  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_o); // R1

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= LW'(DEPTH)); // R5

  AST_RX_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= LW'(DEPTH)); // R5

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush |=> tx_cnt == '0); // R8

  AST_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush |=> rx_cnt == '0); // R8

  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !in_cmd && cur_addr == 7'h7F |=> cur_addr == 7'h7F); // R3

  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags == '0 |=> irq_n_o); // R7
endmodule

bind spi_rf_regif spi_rf_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
  .clk_i, .rst_ni, .cs_ni, .miso_o, .irq_n_o,
  .tx_cnt, .rx_cnt, .tx_flush, .rx_flush, .flags,
  .byte_done, .in_cmd, .cur_addr
);

// File: tb/test_spi_rf_regif.sv
module test_spi_rf_regif;
  localparam int DEPTH = 8;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq_n, tx_empty;
  logic [7:0] mode, tx_data;
  logic [1:0] pwr = 2'b00;
  logic [15:0] evt = '0;
  logic tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0] rx_data = '0;

  always #2.5 clk = ~clk;

  spi_rf_regif #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) i_spi_rf_regif (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .irq_n_o(irq_n), .mode_o(mode), .pwr_state_i(pwr), .evt_i(evt),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_data)
  );

  int checks = 0, errors = 0;
  bit quiet = 0;
  logic [15:0] m_flags = '0, m_en = '0;
  logic [7:0] m_mode = '0, m_fctl = '0;
  logic [7:0] q_tx[$], q_rx[$], sq[$], rq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model
  task automatic m_read(input logic [6:0] a, output logic [7:0] v);
    case (a)
      7'h02: v = {2'b00, (q_rx.size() == 0), 3'b000, pwr};
      7'h03: begin v = m_flags[7:0];  m_flags[7:0]  = '0; end
      7'h04: begin v = m_flags[15:8]; m_flags[15:8] = '0; end
      7'h05: v = m_en[7:0];
      7'h06: v = m_en[15:8];
      7'h07: v = m_mode;
      7'h08: v = m_fctl;
      7'h7F: if (q_rx.size() == 0) begin v = 8'h00; m_flags[7] = 1'b1; end
             else v = q_rx.pop_front();
      default: v = 8'h00;
    endcase
  endtask

  task automatic m_write(input logic [6:0] a, input logic [7:0] d);
    case (a)
      7'h05: m_en[7:0]  = d;
      7'h06: m_en[15:8] = d;
      7'h07: m_mode     = d;
      7'h08: begin
        if (m_fctl[0] && !d[0]) q_tx.delete();
        if (m_fctl[1] && !d[1]) q_rx.delete();
        m_fctl = d;
      end
      7'h7F: if (q_tx.size() == DEPTH) m_flags[7] = 1'b1; else q_tx.push_back(d);
      default: ;
    endcase
  endtask

  // every clock while idle: outputs against the model
  always @(negedge clk) begin
    if (quiet) begin
      chk("R7 irq_n", irq_n, ~|(m_flags & m_en));
      chk("R4 mode_o", mode, m_mode);
      chk("R3 tx_empty", tx_empty, q_tx.size() == 0);
      if (q_tx.size() != 0) chk("R3 tx_data", tx_data, q_tx[0]);
    end
  end

  // drive the bytes in sq; last byte cut to last_bits; check reads against model
  task automatic spi(input string tag, input int last_bits);
    logic [7:0] r, v;
    logic [6:0] a;
    int nfull;
    quiet = 0;
    rq.delete();
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < sq.size(); k++) begin
      int nb = (k == sq.size() - 1) ? last_bits : 8;
      r = '0;
      for (int i = 0; i < nb; i++) begin
        mosi = sq[k][7-i];
        repeat (H) @(negedge clk);
        r = {r[6:0], miso};
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
      if (nb == 8) rq.push_back(r);
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * H) @(negedge clk);
    chk({tag, " R1 cmd miso"}, rq[0], 8'h00);
    nfull = (last_bits == 8) ? sq.size() : sq.size() - 1;
    a = sq[0][6:0];
    for (int k = 1; k < nfull; k++) begin
      if (sq[0][7]) m_write(a, sq[k]);
      else begin
        m_read(a, v);
        chk(tag, rq[k], v);
      end
      a = (a == 7'h7F) ? a : a + 7'd1;
    end
    sq.delete();
    quiet = 1;
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    quiet = 0;
    @(negedge clk) evt = v;
    @(negedge clk) evt = '0;
    m_flags = m_flags | v;
    repeat (4) @(negedge clk);
    quiet = 1;
  endtask

  task automatic radio_push(input logic [7:0] d);
    quiet = 0;
    @(negedge clk) begin rx_data = d; rx_push = 1'b1; end
    @(negedge clk) rx_push = 1'b0;
    if (q_rx.size() == DEPTH) m_flags[7] = 1'b1; else q_rx.push_back(d);
    repeat (4) @(negedge clk);
    quiet = 1;
  endtask

  task automatic radio_pop();
    quiet = 0;
    @(negedge clk) tx_pop = 1'b1;
    @(negedge clk) tx_pop = 1'b0;
    if (q_tx.size() == 0) m_flags[7] = 1'b1; else void'(q_tx.pop_front());
    repeat (4) @(negedge clk);
    quiet = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 irq_n", irq_n, 1'b1);
    chk("R12 miso", miso, 1'b0);
    chk("R12 mode", mode, 8'h00);
    chk("R12 tx_empty", tx_empty, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet = 1;
    sq = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    spi("R12 regs after reset", 8);

    // R4 mode write
    sq = '{8'h87, 8'h01}; spi("R4", 8);
    chk("R4 mode_o", mode, 8'h01);

    // R2 burst write and burst read
    sq = '{8'h85, 8'h81, 8'h01, 8'h5A}; spi("R2 write", 8);
    sq = '{8'h05, 8'h00, 8'h00, 8'h00, 8'h00}; spi("R2 read", 8);
    chk("R2 mode after burst", mode, 8'h5A);

    // R7 / R6 flags and interrupt
    pulse_evt(16'h0001);
    chk("R7 irq asserted", irq_n, 1'b0);
    pulse_evt(16'h0100);
    sq = '{8'h03, 8'h00}; spi("R6 read lo", 8);
    chk("R7 irq held by hi flag", irq_n, 1'b0);
    sq = '{8'h04, 8'h00}; spi("R6 read hi", 8);
    chk("R7 irq released", irq_n, 1'b1);
    pulse_evt(16'h0006);
    chk("R7 disabled flag no irq", irq_n, 1'b1);
    sq = '{8'h03}; spi("R6 command only", 8);
    sq = '{8'h03, 8'h00}; spi("R6 unclocked kept", 8);
    chk("R6 flags read once", rq[1], 8'h06);
    sq = '{8'h03, 8'h00}; spi("R6 cleared", 8);

    // R3 gateway
    sq = '{8'hFF, 8'h11, 8'h22, 8'h33}; spi("R3 gate write", 8);
    chk("R3 first byte", tx_data, 8'h11);
    radio_pop(); radio_pop(); radio_pop();
    sq = '{8'hFE, 8'hAA, 8'hBB, 8'hCC}; spi("R3 from 0x7E", 8);
    chk("R3 0x7E skipped", tx_data, 8'hBB);
    radio_pop(); radio_pop();

    // R5 TX overflow and underflow
    sq = '{8'hFF, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
    spi("R5 tx fill", 8);
    sq = '{8'h03, 8'h00}; spi("R5 overflow flag", 8);
    chk("R5 overflow flag", rq[1], 8'h80);
    for (int i = 0; i < DEPTH + 1; i++) radio_pop();
    sq = '{8'h03, 8'h00}; spi("R5 underflow flag", 8);

    // R8 FIFO clears
    sq = '{8'hFF, 8'h44, 8'h55}; spi("R8 tx refill", 8);
    sq = '{8'h88, 8'h03}; spi("R8 set", 8);
    chk("R8 tx kept while bit high", tx_empty, 1'b0);
    radio_push(8'h66);
    sq = '{8'h88, 8'h00}; spi("R8 clear", 8);
    chk("R8 tx emptied", tx_empty, 1'b1);
    pwr = 2'b01;
    sq = '{8'h02, 8'h00}; spi("R9 rx empty after clear", 8);
    chk("R9 status", rq[1], 8'h21);

    // R9 status and R3/R5 RX path
    radio_push(8'hC1); radio_push(8'hC2); radio_push(8'hC3);
    pwr = 2'b10;
    sq = '{8'h02, 8'h00}; spi("R9 status nonempty", 8);
    chk("R9 status", rq[1], 8'h02);
    sq = '{8'hFF & 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00}; spi("R3 gate read", 8);
    chk("R5 empty read returns zero", rq[4], 8'h00);
    sq = '{8'h03, 8'h00}; spi("R5 rx underflow flag", 8);
    for (int i = 0; i < DEPTH + 1; i++) radio_push(8'(i + 8'h30));
    sq = '{8'h03, 8'h00}; spi("R5 rx overflow flag", 8);
    sq = '{8'h7F, 8'h00, 8'h00}; spi("R3 rx order", 8);

    // R10 unimplemented and read-only addresses
    sq = '{8'hA0, 8'h55}; spi("R10 write unimpl", 8);
    sq = '{8'h20, 8'h00}; spi("R10 read unimpl", 8);
    chk("R10 unimpl reads zero", rq[1], 8'h00);
    pulse_evt(16'h0010);
    sq = '{8'h82, 8'hFF, 8'h00, 8'h00}; spi("R10 write status/flags", 8);
    sq = '{8'h03, 8'h00}; spi("R10 flags untouched", 8);
    chk("R10 flags untouched", rq[1], 8'h10);

    // R11 partial byte
    sq = '{8'h87, 8'h33}; spi("R11 partial", 4);
    chk("R11 mode unchanged", mode, 8'h5A);
    sq = '{8'h87, 8'h3C}; spi("R11 after abort", 8);
    chk("R11 write after abort", mode, 8'h3C);

    quiet = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule